// File: doc/BRIEF.md
# RS-485 Transmit Direction Controller

This block sits on the transmit side of an asynchronous serial port and drives the direction-enable pin of an external half-duplex RS-485 transceiver. Bytes enter a 16-entry queue through a one-cycle write strobe. A serial shifter sends each byte as an 8N1 frame, paced by an external baud tick. A two-state direction machine holds the transceiver in the transmit state from the moment a byte is accepted. It does not release the line until the queue is empty and the shifter has finished the stop bit of the last character.

Automatic direction mode can be turned on in two ways: an active-low strap pin forces it on, or a register enable bit turns it on while the strap is high. When the mode is off, the pin carries a software-controlled request-to-send level. A polarity bit sets which pin level means "transmit".

The shifter has four states. `SH_IDLE` loads the head of the queue when one is present, which moves it to `SH_START`. After 16 ticks `SH_START` moves to `SH_DATA`. After 8 data bits `SH_DATA` moves to `SH_STOP`. After 16 ticks `SH_STOP` returns to `SH_IDLE`. The direction machine has two states. `DIR_RX` moves to `DIR_TX` when a write is accepted. `DIR_TX` moves back to `DIR_RX` when the transmitter is empty and no write is accepted in that cycle.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, `txd` is 1, `dir_out` is 1 and `ovf_flag` is 0.
- R2: Each frame on `txd` is one start bit (0), eight data bits sent least significant bit first, and one stop bit (1). Each bit lasts 16 baud ticks. The line idles at 1.
- R3: The queue holds up to 16 bytes and sends them in write order. A byte written into an empty, idle transmitter starts its start bit at the second clock edge after the write.
- R4: A write made while the queue already holds 16 bytes is dropped, even if a byte leaves in the same cycle. It sets `ovf_flag`, which then stays at 1 until reset.
- R5: In automatic mode, `dir_out` takes the transmit level at the clock edge that accepts a write.
- R6: In automatic mode, `dir_out` returns to the receive level one clock after the shifter leaves its last stop bit with the queue empty. It does not change between characters that are queued back to back.
- R7: With `pol_inv` = 0 the transmit level is 0 and the receive level is 1. With `pol_inv` = 1 the transmit level is 1 and the receive level is 0.
- R8: Automatic mode is on whenever `auto_strap_n` is 0, whatever `auto_en_reg` holds. When `auto_strap_n` is 1, `auto_en_reg` = 1 turns automatic mode on.
- R9: When automatic mode is off, `dir_out` equals the value `sw_rts` had at the previous clock edge, and queued traffic has no effect on it.
- R10: A write accepted in the same cycle that the transmitter would otherwise release the line keeps `dir_out` at the transmit level with no glitch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to queue |
| baud_tick | input | 1 | Single-cycle pulse, 16 per bit period |
| auto_strap_n | input | 1 | Strap pin, active low, forces automatic direction mode |
| auto_en_reg | input | 1 | Register bit that enables automatic mode when the strap is high |
| pol_inv | input | 1 | 1 makes the transmit level high |
| sw_rts | input | 1 | Software level for the pin in manual mode |
| txd | output | 1 | Serial transmit data |
| dir_out | output | 1 | Registered transceiver direction pin |
| ovf_flag | output | 1 | Sticky queue-overflow flag |

## Verification
Two functions can land on the same clock edge: the release of the direction pin, once the transmitter becomes empty, and the acceptance of a new write, which must keep the pin at the transmit level. The bench uses its reference model to find the exact cycle in which the shifter has gone idle with an empty queue while the pin still shows transmit. It drives a write in that cycle. It then requires the pin to stay at the transmit level with exactly two transitions over the whole episode. A second collision is the queue running full while the shifter pops: this is provoked with the baud ticks stopped, and the overflow flag and the order of the bytes sent afterwards are checked.

// File: rtl/rs485_pkg.sv
package rs485_pkg;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_START,
        SH_DATA,
        SH_STOP
    } shift_state_t;

    typedef enum logic {
        DIR_RX,
        DIR_TX
    } dir_state_t;

endpackage

// File: rtl/rs485_txq.sv
module rs485_txq #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic             empty,
    output logic             full,
    output logic             accepted,
    output logic             ovf_flag,
    output logic [$clog2(DEPTH+1)-1:0] level
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic [CW-1:0]    count;
    logic             do_pop;

    // Fullness is judged on the count held before this edge
    assign full      = (count == CNT_FULL);
    assign empty     = (count == '0);
    assign accepted  = push && !full;
    assign do_pop    = pop && !empty;
    assign head_data = mem[rd_ptr];
    assign level     = count;

    always_ff @(posedge clk) begin
        if (accepted) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (accepted) begin
            wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (do_pop) begin
            rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case ({accepted, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
        end else if (push && full) begin
            ovf_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/rs485_shifter.sv
module rs485_shifter
    import rs485_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int TICKS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic             avail,
    input  logic [WIDTH-1:0] load_data,
    output logic             take,
    output logic             txd,
    output logic             idle
);

    localparam int TW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [TW-1:0] TICK_LAST = TW'(TICKS - 1);
    localparam logic [BW-1:0] BIT_LAST  = BW'(WIDTH - 1);

    shift_state_t     state;
    shift_state_t     state_nxt;
    logic [TW-1:0]    tick_cnt;
    logic [BW-1:0]    bit_cnt;
    logic [WIDTH-1:0] shreg;
    logic             bit_end;

    assign bit_end = baud_tick && (tick_cnt == TICK_LAST);

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            SH_IDLE:  if (avail)   state_nxt = SH_START;
            SH_START: if (bit_end) state_nxt = SH_DATA;
            SH_DATA:  if (bit_end && (bit_cnt == BIT_LAST)) state_nxt = SH_STOP;
            SH_STOP:  if (bit_end) state_nxt = SH_IDLE;
            default:  state_nxt = SH_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SH_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Bit timing and data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            bit_cnt  <= '0;
            shreg    <= '0;
        end else begin
            unique case (state)
                SH_IDLE: begin
                    tick_cnt <= '0;
                    bit_cnt  <= '0;
                    if (avail) begin
                        shreg <= load_data;
                    end
                end
                SH_START, SH_STOP: begin
                    if (baud_tick) begin
                        tick_cnt <= bit_end ? '0 : tick_cnt + 1'b1;
                    end
                end
                SH_DATA: begin
                    if (baud_tick) begin
                        tick_cnt <= bit_end ? '0 : tick_cnt + 1'b1;
                    end
                    if (bit_end) begin
                        shreg   <= shreg >> 1;
                        bit_cnt <= (bit_cnt == BIT_LAST) ? '0 : bit_cnt + 1'b1;
                    end
                end
                default: begin
                    tick_cnt <= '0;
                    bit_cnt  <= '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        take = 1'b0;
        txd  = 1'b1;
        idle = 1'b0;
        unique case (state)
            SH_IDLE: begin
                idle = 1'b1;
                take = avail;
            end
            SH_START: txd = 1'b0;
            SH_DATA:  txd = shreg[0];
            SH_STOP:  txd = 1'b1;
            default:  txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
    import rs485_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_accept,
    input  logic tx_empty,
    input  logic auto_on,
    input  logic pol_inv,
    input  logic sw_rts,
    output logic dir_out
);

    dir_state_t state;
    dir_state_t state_nxt;
    logic       pin_nxt;
    logic       pin_q;

    // Next-state logic: a new write always wins over the release
    always_comb begin
        state_nxt = state;
        unique case (state)
            DIR_RX: if (wr_accept) state_nxt = DIR_TX;
            DIR_TX: if (tx_empty && !wr_accept) state_nxt = DIR_RX;
            default: state_nxt = DIR_RX;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= DIR_RX;
        end else begin
            state <= state_nxt;
        end
    end

    // Pin level chosen from the next state so the pin moves on the same edge
    always_comb begin
        if (auto_on) begin
            pin_nxt = (state_nxt == DIR_TX) ? pol_inv : !pol_inv;
        end else begin
            pin_nxt = sw_rts;
        end
    end

    // Registered output, glitch-free
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= 1'b1;
        end else begin
            pin_q <= pin_nxt;
        end
    end

    assign dir_out = pin_q;

endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    parameter int TICKS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             baud_tick,
    input  logic             auto_strap_n,
    input  logic             auto_en_reg,
    input  logic             pol_inv,
    input  logic             sw_rts,
    output logic             txd,
    output logic             dir_out,
    output logic             ovf_flag
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] head_data;
    logic             q_empty;
    logic             q_full;
    logic             wr_accept;
    logic             take;
    logic             sh_idle;
    logic             tx_empty;
    logic             auto_on;
    logic [CW-1:0]    q_level;

    // Strap (active low) overrides; otherwise the register bit decides
    assign auto_on  = !auto_strap_n || auto_en_reg;
    assign tx_empty = q_empty && sh_idle;

    rs485_txq #(
        .DEPTH (DEPTH),
        .WIDTH (WIDTH)
    ) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (take),
        .head_data (head_data),
        .empty     (q_empty),
        .full      (q_full),
        .accepted  (wr_accept),
        .ovf_flag  (ovf_flag),
        .level     (q_level)
    );

    rs485_shifter #(
        .WIDTH (WIDTH),
        .TICKS (TICKS)
    ) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .avail     (!q_empty),
        .load_data (head_data),
        .take      (take),
        .txd       (txd),
        .idle      (sh_idle)
    );

    rs485_dir_fsm u_dir (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_accept (wr_accept),
        .tx_empty  (tx_empty),
        .auto_on   (auto_on),
        .pol_inv   (pol_inv),
        .sw_rts    (sw_rts),
        .dir_out   (dir_out)
    );

endmodule

// File: rtl/rs485_dir_ctrl_chk.sv
module rs485_dir_ctrl_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          wr_accept,
    input logic          auto_on,
    input logic          pol_inv,
    input logic          sw_rts,
    input logic          dir_out,
    input logic          ovf_flag,
    input logic          q_empty,
    input logic          q_full,
    input logic          take,
    input logic [CW-1:0] q_level
);

    a_r5_write_sets_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_on && wr_accept) |=> (dir_out == $past(pol_inv)));

    a_r6_hold_while_queued: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_on && !q_empty) |=> (dir_out == $past(pol_inv)));

    a_r9_manual_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_on |=> (dir_out == $past(sw_rts)));

    a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && wr_en && !take) |=> (q_level == CW'(DEPTH)));

    a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q_level <= CW'(DEPTH));

endmodule

bind rs485_dir_ctrl rs485_dir_ctrl_chk #(
    .DEPTH (DEPTH),
    .CW    (CW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_accept (wr_accept),
    .auto_on   (auto_on),
    .pol_inv   (pol_inv),
    .sw_rts    (sw_rts),
    .dir_out   (dir_out),
    .ovf_flag  (ovf_flag),
    .q_empty   (q_empty),
    .q_full    (q_full),
    .take      (take),
    .q_level   (q_level)
);

// File: tb/test_rs485_dir_ctrl.sv
`timescale 1ns/1ps
module test_rs485_dir_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       baud_tick = 1'b0;
    logic       auto_strap_n = 1'b0;
    logic       auto_en_reg = 1'b0;
    logic       pol_inv = 1'b0;
    logic       sw_rts = 1'b0;
    logic       txd;
    logic       dir_out;
    logic       ovf_flag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int toggles = 0;
    logic prev_dir = 1'b1;
    logic tick_en = 1'b0;
    int tick_div = 2;
    int tick_cnt = 0;
    string txd_tag = "R2";
    string dir_tag = "R6";
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rs485_dir_ctrl i_rs485_dir_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .baud_tick    (baud_tick),
        .auto_strap_n (auto_strap_n),
        .auto_en_reg  (auto_en_reg),
        .pol_inv      (pol_inv),
        .sw_rts       (sw_rts),
        .txd          (txd),
        .dir_out      (dir_out),
        .ovf_flag     (ovf_flag)
    );

    // Reference model state
    logic [7:0] q[$];
    bit   m_busy, m_dir_tx, m_pin, m_ovf, m_acc, m_empty_pre, m_ld, m_auto;
    int   m_bit, m_tick, m_sz;
    logic [7:0] m_byte;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic logic exp_txd();
        if (!m_busy) return 1'b1;
        if (m_bit == 0) return 1'b0;
        if (m_bit == 9) return 1'b1;
        return m_byte[m_bit-1];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.delete();
            m_busy = 0; m_bit = 0; m_tick = 0; m_byte = 0;
            m_dir_tx = 0; m_pin = 1; m_ovf = 0;
        end else begin
            m_sz = q.size();
            m_empty_pre = (m_sz == 0) && !m_busy;
            m_acc = wr_en && (m_sz < 16);
            m_ld = !m_busy && (m_sz > 0);
            m_auto = !auto_strap_n || auto_en_reg;
            if (wr_en && m_sz >= 16) m_ovf = 1;
            if (m_acc) m_dir_tx = 1;
            else if (m_empty_pre) m_dir_tx = 0;
            m_pin = m_auto ? (m_dir_tx ? pol_inv : !pol_inv) : sw_rts;
            if (m_ld) begin
                m_byte = q.pop_front();
                m_busy = 1; m_bit = 0; m_tick = 0;
            end else if (m_busy && baud_tick) begin
                if (m_tick == 15) begin
                    m_tick = 0;
                    if (m_bit == 9) m_busy = 0;
                    else m_bit++;
                end else begin
                    m_tick++;
                end
            end
            if (m_acc) q.push_back(wr_data);
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            chk(txd_tag, txd, exp_txd());
            chk(dir_tag, dir_out, m_pin);
            chk("R4", ovf_flag, m_ovf);
            if (dir_out != prev_dir) toggles++;
            prev_dir = dir_out;
        end
    end

    // Baud tick generator
    always @(negedge clk) begin
        if (tick_en) begin
            tick_cnt <= (tick_cnt >= tick_div - 1) ? 0 : tick_cnt + 1;
            baud_tick <= (tick_cnt >= tick_div - 1);
        end else begin
            baud_tick <= 1'b0;
        end
    end

    // Watchdog
    always @(negedge clk) begin
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual %0d expected below %0d", cycles, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic write_burst(input int n, input logic [7:0] base);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            wr_en = 1'b1;
            wr_data = base + 8'(i * 37);
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic drain();
        int guard = 0;
        while ((q.size() != 0 || m_busy || m_dir_tx) && guard < 40000) begin
            @(negedge clk);
            guard++;
        end
        repeat (2) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 txd", txd, 1);
        chk("R1 dir_out", dir_out, 1);
        chk("R1 ovf_flag", ovf_flag, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 txd after release", txd, 1);
        chk("R1 dir_out after release", dir_out, 1);
        tick_en = 1'b1;

        // Single byte, strap-forced automatic mode
        toggles = 0;
        dir_tag = "R5";
        write_byte(8'hA5);
        #1;
        chk("R5 transmit level after write", dir_out, 0);
        dir_tag = "R6";
        @(negedge clk); #1;
        chk("R3 start bit begins", txd, 0);
        drain();
        chk("R6 receive level after drain", dir_out, 1);
        chk("R6 two transitions single byte", toggles, 2);

        // Back-to-back characters
        toggles = 0;
        write_burst(3, 8'h3C);
        drain();
        chk("R6 no toggle between queued chars", toggles, 2);

        // Inverted polarity
        pol_inv = 1'b1;
        dir_tag = "R7";
        repeat (2) @(negedge clk); #1;
        chk("R7 inverted receive level", dir_out, 0);
        write_byte(8'h81);
        #1;
        chk("R7 inverted transmit level", dir_out, 1);
        drain();
        chk("R7 inverted level after drain", dir_out, 0);
        pol_inv = 1'b0;
        repeat (2) @(negedge clk);

        // Register-enabled automatic mode and manual mode
        dir_tag = "R8";
        auto_strap_n = 1'b1;
        auto_en_reg = 1'b1;
        write_byte(8'h5A);
        #1;
        chk("R8 register-enabled auto transmit", dir_out, 0);
        drain();
        auto_en_reg = 1'b0;
        sw_rts = 1'b0;
        dir_tag = "R9";
        repeat (2) @(negedge clk); #1;
        chk("R9 manual follows sw_rts low", dir_out, 0);
        sw_rts = 1'b1;
        @(negedge clk); #1;
        chk("R9 manual follows sw_rts high", dir_out, 1);
        toggles = 0;
        dir_tag = "R8";
        write_byte(8'hC3);
        #1;
        chk("R8 manual mode ignores traffic", dir_out, 1);
        drain();
        chk("R9 no toggle in manual mode", toggles, 0);
        auto_strap_n = 1'b0;
        sw_rts = 1'b0;
        repeat (2) @(negedge clk);

        // Overflow with the shifter stalled
        dir_tag = "R6";
        txd_tag = "R3";
        tick_en = 1'b0;
        write_burst(18, 8'h11);
        #1;
        chk("R4 overflow flag set", ovf_flag, 1);
        tick_div = 1;
        tick_en = 1'b1;
        drain();
        chk("R4 overflow flag sticky", ovf_flag, 1);
        txd_tag = "R2";

        // Write colliding with the release cycle
        tick_div = 3;
        toggles = 0;
        dir_tag = "R10";
        write_byte(8'h96);
        begin
            int guard = 0;
            while (!(q.size() == 0 && !m_busy && m_dir_tx) && guard < 40000) begin
                @(negedge clk);
                guard++;
            end
        end
        wr_en = 1'b1;
        wr_data = 8'h69;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk("R10 transmit level held on collision", dir_out, 0);
        drain();
        chk("R10 two transitions across collision", toggles, 2);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule